// File: doc/BRIEF.md
# Phase Offset Recalibration Sequencer

This block re-zeroes the phase relationship between a set of generated output clocks and the reference they track, and it leaves the programmed output phase where it was. In normal operation the applied phase offset that goes to the loop simply follows the stored target offset, one cycle later. A register write of 1 to a self-clearing control bit starts a recalibration. The block then asks the loop for a short holdover and walks the applied offset down to zero in bounded steps. With the offset at zero it pulses a reset to the output dividers, walks the offset back up to the stored target, and drops the holdover request. The control bit reads back as 1 for the whole sequence and returns to 0 on its own.

The applied offset is a signed two's-complement value, so each ramp can move up or down. Each ramp step happens once every `RAMP_DIV` clock cycles and moves the offset by a programmable magnitude. The last step of a ramp is clamped so that it lands exactly on its goal. The loop filter and the dividers are outside this block.

States: `ST_IDLE` (the offset tracks the target), `ST_HOLD` (holdover requested, one cycle), `ST_RAMP_DN` (stepping toward zero), `ST_DIV_RST` (divider reset pulse, one cycle), `ST_RAMP_UP` (stepping toward the target), `ST_RELEASE` (holdover dropped, bit still set, one cycle). Transitions: IDLE→HOLD on a start write; HOLD→RAMP_DN unconditionally; RAMP_DN→DIV_RST once the offset equals zero; DIV_RST→RAMP_UP unconditionally; RAMP_UP→RELEASE once the offset equals the target; RELEASE→IDLE unconditionally.

Top module: `phase_recal_seq`

## Requirements
- R1: After reset, `recal_bit`, `holdover_req` and `div_rst` are 0 and `applied_ofs` is 0.
- R2: While idle, `applied_ofs` equals the `target_ofs` value seen one clock earlier. A write with `wr_data` = 0 has no effect on any output.
- R3: A write with `wr_data` = 1 while `recal_bit` is 0 makes both `recal_bit` and `holdover_req` read 1 from the next cycle.
- R4: While `holdover_req` is 1, `applied_ofs` changes by no more than max(`step`,1) per cycle. The downward ramp never crosses zero.
- R5: `div_rst` is a one-cycle pulse and occurs exactly once per sequence. During the pulse `applied_ofs` is 0, `holdover_req` is 1 and `recal_bit` is 1.
- R6: After the pulse, `applied_ofs` ramps toward `target_ofs` and never passes it.
- R7: `holdover_req` falls only when `applied_ofs` equals `target_ofs` and `recal_bit` is still 1. `recal_bit` clears one cycle later.
- R8: When a sequence completes, `applied_ofs` equals its value before the trigger. Positive, negative and zero targets all behave this way.
- R9: A write of 1 while `recal_bit` is 1 is ignored: the running sequence is not restarted and produces only one divider pulse.
- R10: A `step` of 0 is treated as 1. A step larger than the remaining distance lands exactly on the goal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 1 | Value written to the control bit |
| target_ofs | input | OFS_W | Stored target phase offset, signed |
| step | input | STEP_W | Ramp step magnitude, unsigned |
| applied_ofs | output | OFS_W | Phase offset applied to the loop, signed |
| holdover_req | output | 1 | Requests a short holdover from the loop |
| div_rst | output | 1 | Single-cycle reset for the output dividers |
| recal_bit | output | 1 | Control bit readback; 1 while busy |

## Verification
A state register stuck or skipping a step shows up at the ports within a few cycles. `recal_bit` would never clear, or `div_rst` would fire with a nonzero offset or twice. `holdover_req` could also fall before the offset is back at the target. A faulty stepper shows up on the first ramp tick as a jump larger than the step or as a crossing past zero or past the target. It also shows up at the end of the sequence as a final offset different from the starting one. A broken idle path is visible one cycle after the target changes.

// File: rtl/prs_pkg.sv
package prs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_RAMP_DN = 3'd2,
        ST_DIV_RST = 3'd3,
        ST_RAMP_UP = 3'd4,
        ST_RELEASE = 3'd5
    } prs_state_e;
endpackage

// File: rtl/prs_tick.sv
module prs_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = run && (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/prs_ramp_step.sv
module prs_ramp_step #(
    parameter int W  = 16,
    parameter int SW = 8
) (
    input  logic signed [W-1:0] cur,
    input  logic signed [W-1:0] goal,
    input  logic        [SW-1:0] step,
    output logic signed [W-1:0] nxt
);
    localparam int DW = W + 1;
    logic        [SW-1:0] step_eff;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] mag;
    logic signed [DW-1:0] stp;

    always_comb begin
        step_eff = (step == '0) ? SW'(1) : step;
        stp      = signed'({{(DW-SW){1'b0}}, step_eff});
        diff     = signed'({goal[W-1], goal}) - signed'({cur[W-1], cur});
        mag      = (diff < 0) ? -diff : diff;
        if (mag <= stp) begin
            nxt = goal;
        end else if (diff < 0) begin
            nxt = cur - stp[W-1:0];
        end else begin
            nxt = cur + stp[W-1:0];
        end
    end
endmodule

// File: rtl/prs_fsm.sv
module prs_fsm
    import prs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       at_zero,
    input  logic       at_goal,
    output prs_state_e state,
    output logic       holdover_req,
    output logic       div_rst,
    output logic       busy
);
    prs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)   state_d = ST_HOLD;
            ST_HOLD:                 state_d = ST_RAMP_DN;
            ST_RAMP_DN: if (at_zero) state_d = ST_DIV_RST;
            ST_DIV_RST:              state_d = ST_RAMP_UP;
            ST_RAMP_UP: if (at_goal) state_d = ST_RELEASE;
            ST_RELEASE:              state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        holdover_req = 1'b0;
        div_rst      = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_HOLD,
            ST_RAMP_DN,
            ST_RAMP_UP: holdover_req = 1'b1;
            ST_DIV_RST: begin
                holdover_req = 1'b1;
                div_rst      = 1'b1;
            end
            ST_RELEASE: holdover_req = 1'b0;
            default:    busy = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/phase_recal_seq.sv
module phase_recal_seq
    import prs_pkg::*;
#(
    parameter int OFS_W    = 16,
    parameter int STEP_W   = 8,
    parameter int RAMP_DIV = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_data,
    input  logic signed [OFS_W-1:0] target_ofs,
    input  logic        [STEP_W-1:0] step,
    output logic signed [OFS_W-1:0] applied_ofs,
    output logic                    holdover_req,
    output logic                    div_rst,
    output logic                    recal_bit
);
    localparam logic signed [OFS_W-1:0] ZERO_OFS = '0;

    prs_state_e              state;
    logic                    ramping;
    logic                    tick;
    logic signed [OFS_W-1:0] ofs_q;
    logic signed [OFS_W-1:0] nxt_dn;
    logic signed [OFS_W-1:0] nxt_up;
    logic                    at_zero;
    logic                    at_goal;

    assign at_zero = (ofs_q == ZERO_OFS);
    assign at_goal = (ofs_q == target_ofs);
    assign ramping = (state == ST_RAMP_DN) || (state == ST_RAMP_UP);

    prs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (wr_en && wr_data),
        .at_zero      (at_zero),
        .at_goal      (at_goal),
        .state        (state),
        .holdover_req (holdover_req),
        .div_rst      (div_rst),
        .busy         (recal_bit)
    );

    prs_tick #(.DIV(RAMP_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ramping),
        .tick  (tick)
    );

    prs_ramp_step #(.W(OFS_W), .SW(STEP_W)) u_step_dn (
        .cur  (ofs_q),
        .goal (ZERO_OFS),
        .step (step),
        .nxt  (nxt_dn)
    );

    prs_ramp_step #(.W(OFS_W), .SW(STEP_W)) u_step_up (
        .cur  (ofs_q),
        .goal (target_ofs),
        .step (step),
        .nxt  (nxt_up)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE:    ofs_q <= target_ofs;
                ST_RAMP_DN: if (tick) ofs_q <= nxt_dn;
                ST_RAMP_UP: if (tick) ofs_q <= nxt_up;
                default:    ofs_q <= ofs_q;
            endcase
        end
    end

    assign applied_ofs = ofs_q;
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int OFS_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    wr_data,
    input logic signed [OFS_W-1:0] target_ofs,
    input logic signed [OFS_W-1:0] applied_ofs,
    input logic                    holdover_req,
    input logic                    div_rst,
    input logic                    recal_bit
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!recal_bit && !holdover_req && !div_rst));

    a_r2_idle_track: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !recal_bit && !$past(recal_bit)) |-> (applied_ofs == $past(target_ofs)));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data && !recal_bit) |=> (recal_bit && holdover_req));

    a_r5_div_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> !div_rst);

    a_r5_div_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |-> (applied_ofs == '0 && holdover_req && recal_bit));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(holdover_req) |-> (recal_bit && applied_ofs == target_ofs));

    a_r7_hold_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        holdover_req |-> recal_bit);
endmodule

bind phase_recal_seq prs_checker #(.OFS_W(OFS_W)) u_prs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .target_ofs   (target_ofs),
    .applied_ofs  (applied_ofs),
    .holdover_req (holdover_req),
    .div_rst      (div_rst),
    .recal_bit    (recal_bit)
);

// File: tb/tb_phase_recal_seq.sv
module tb_phase_recal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int OFS_W  = 16;
    localparam int STEP_W = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en = 1'b0;
    logic                    wr_data = 1'b0;
    logic signed [OFS_W-1:0] target_ofs = '0;
    logic        [STEP_W-1:0] step = 8'd1;
    logic signed [OFS_W-1:0] applied_ofs;
    logic                    holdover_req;
    logic                    div_rst;
    logic                    recal_bit;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_recal_seq #(.OFS_W(OFS_W), .STEP_W(STEP_W)) dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .target_ofs (target_ofs), .step (step), .applied_ofs (applied_ofs),
        .holdover_req (holdover_req), .div_rst (div_rst), .recal_bit (recal_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int t, input int s);
        @(negedge clk);
        target_ofs = OFS_W'(t);
        step = STEP_W'(s);
        repeat (3) @(negedge clk);
    endtask

    // one full sequence; optionally a second write of 1 mid-run (R9)
    task automatic run_recal(input int t, input int s, input bit extra_write);
        int start_val, prev, cur, step_eff, pulses, cyc, moves_bad, cross_bad, over_bad;
        bit after_pulse, fell_ok, fell_seen, ramp_dn_seen;
        settle(t, s);
        step_eff = (s == 0) ? 1 : s;
        start_val = int'(applied_ofs);
        check(start_val == t, "R2 idle tracking", start_val, t);
        wr_en = 1'b1; wr_data = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 1'b0;
        check(recal_bit && holdover_req, "R3 start", {recal_bit, holdover_req}, 3);
        prev = int'(applied_ofs);
        pulses = 0; cyc = 0; moves_bad = 0; cross_bad = 0; over_bad = 0;
        after_pulse = 0; fell_ok = 0; fell_seen = 0; ramp_dn_seen = 0;
        while (recal_bit && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (extra_write && cyc == 6) begin wr_en = 1'b1; wr_data = 1'b1; end
            else begin wr_en = 1'b0; wr_data = 1'b0; end
            cur = int'(applied_ofs);
            if (holdover_req && ((cur - prev) > step_eff || (prev - cur) > step_eff)) moves_bad++;
            if (!after_pulse && ((t > 0 && cur < 0) || (t < 0 && cur > 0))) cross_bad++;
            if (after_pulse && ((t >= 0 && cur > t) || (t <= 0 && cur < t) ||
                                (t > 0 && cur < 0) || (t < 0 && cur > 0))) over_bad++;
            if (div_rst) begin
                pulses++;
                after_pulse = 1;
                check(cur == 0 && holdover_req, "R5 zero at pulse", cur, 0);
            end
            if (!holdover_req && recal_bit && !fell_seen) begin
                fell_seen = 1;
                fell_ok = (cur == t) && after_pulse;
            end
            if (cur != start_val) ramp_dn_seen = 1;
            prev = cur;
        end
        wr_en = 1'b0; wr_data = 1'b0;
        check(cyc < 20000, "R7 bit self-clears", cyc, 0);
        check(pulses == 1, extra_write ? "R9 single pulse despite busy write" : "R5 one pulse", pulses, 1);
        check(moves_bad == 0, (s == 0) ? "R10 step zero as one" : "R4 step bound", moves_bad, 0);
        check(cross_bad == 0, "R4 no zero crossing", cross_bad, 0);
        check(over_bad == 0, (s > 40) ? "R10 clamp on goal" : "R6 no overshoot", over_bad, 0);
        check(fell_seen && fell_ok, "R7 release at target", fell_ok, 1);
        check(!recal_bit && !holdover_req && !div_rst, "R7 quiet after end",
              {recal_bit, holdover_req, div_rst}, 0);
        check(int'(applied_ofs) == start_val, "R8 net offset unchanged", int'(applied_ofs), start_val);
        if (t != 0) check(ramp_dn_seen, "R4 ramp moved offset", ramp_dn_seen, 1);
    endtask

    task automatic test_reset();
        check(!recal_bit && !holdover_req && !div_rst, "R1 outputs idle",
              {recal_bit, holdover_req, div_rst}, 0);
        check(applied_ofs == 0, "R1 offset zero", int'(applied_ofs), 0);
    endtask

    task automatic test_idle_and_zero_write();
        settle(-200, 4);
        check(int'(applied_ofs) == -200, "R2 follow negative", int'(applied_ofs), -200);
        target_ofs = 16'sd77;
        @(negedge clk);
        check(int'(applied_ofs) == 77, "R2 one-cycle follow", int'(applied_ofs), 77);
        wr_en = 1'b1; wr_data = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(!recal_bit && !holdover_req && !div_rst && applied_ofs == 77,
                  "R2 zero write ignored", {recal_bit, holdover_req, div_rst}, 0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_and_zero_write();
        run_recal(100, 7, 0);
        run_recal(-53, 10, 0);
        run_recal(3, 50, 0);
        run_recal(5, 0, 0);
        run_recal(0, 3, 0);
        run_recal(-90, 6, 1);
        run_recal(32767, 255, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule